// File: doc/BRIEF.md
# Floating-Point Register Stack

An eight-slot register file addressed as a stack. A top pointer turns stack-relative indices into physical slots: relative index 0 is always the current top, and relative index i is physical slot (top + i) mod 8. Each slot has a tag that says whether it holds a pushed value. The arithmetic unit sits outside the block. The block gives that unit two operands: the top entry and any selected entry, in the order set by a reverse flag. It takes the unit's result back on the data input and writes it into the selected entry. That write can also remove the top entry in the same operation.

Each cycle takes one operation code. The operation is either a no-op, a push, a pop, an exchange of any two entries, a write-back, or a write-back followed by a pop. A clear input empties every tag at once. If an operation would push onto an occupied slot, it is refused and an overflow pulse follows. If it would pop, swap or overwrite an empty slot, it is refused and an underflow pulse follows. A refused operation leaves the pointer, the tags and the data unchanged. The operand outputs and a read-fault flag are combinational views of the current state.

The control path is decoded by a unique case on an enumerated operation type. The states are the pointer and tag vector. The transitions are the six operations plus clear.

Top module: `fpr_stack`

## Requirements
- R1: After reset, top_o is 0, all bits of tag_o are 0, and ovf_o and unf_o are low.
- R2: Push (op_i = 1) onto an empty slot sets top to (top-1) mod 8, writes data_i there and sets its tag. On the next cycle opnd_a_o (with rev_i = 0) shows the pushed value.
- R3: Pop (op_i = 2) of a valid top clears that slot's tag and sets top to (top+1) mod 8.
- R4: Push onto a slot whose tag is set changes no state. It makes ovf_o high for exactly the following cycle.
- R5: Pop of an empty top, exchange with an empty entry, or write-back or write-back-pop with an empty target (or, for write-back-pop, an empty top) changes no state. It makes unf_o high for exactly the following cycle.
- R6: With rev_i = 0, opnd_a_o is the top entry and opnd_b_o is entry (top + idx_a_i) mod 8. rd_fault_o is high exactly when either of those slots has its tag clear.
- R7: Exchange (op_i = 3) swaps the contents of relative entries idx_a_i and idx_b_i when both are valid. The pointer and tags do not change.
- R8: Write-back (op_i = 4) stores data_i into relative entry idx_a_i when it is valid. The pointer and tags do not change.
- R9: Write-back-pop (op_i = 5) stores data_i into relative entry idx_a_i, then pops the top. When idx_a_i = 1, the result becomes the new top.
- R10: With rev_i = 1, opnd_a_o and opnd_b_o trade places.
- R11: clear_i = 1 clears every tag in one cycle and leaves top unchanged. The operation in that cycle is ignored and raises no flag.
- R12: ovf_o and unf_o are never high together. Both are low in any cycle that does not follow a refused operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clear_i | input | 1 | Empty all tags |
| op_i | input | 3 | Operation code |
| idx_a_i | input | 3 | Relative index: operand, write-back target, first exchange entry |
| idx_b_i | input | 3 | Relative index: second exchange entry |
| rev_i | input | 1 | Swap the two operand outputs |
| data_i | input | W | Push value or result to write back |
| opnd_a_o | output | W | First operand |
| opnd_b_o | output | W | Second operand |
| rd_fault_o | output | 1 | An operand slot is empty |
| top_o | output | 3 | Physical top pointer |
| tag_o | output | 8 | Per-slot valid tags, by physical slot |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |

## Verification
Two actions can land in the same cycle. The first is clear meeting a live operation: the bench issues a push, pop or exchange together with clear_i. It then expects empty tags, an unchanged pointer, unchanged data and no flag. The second is write and pop in one write-back-pop: the bench targets relative entry 0 and entry 1. It checks that the result either vanishes with the popped top or becomes the new top. A behavioural model built from arrays judges every cycle of both cases, and also a long mixed run.

// File: rtl/fpr_stack_pkg.sv
package fpr_stack_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_XCHG  = 3'd3,
        OP_WB    = 3'd4,
        OP_WBPOP = 3'd5
    } fpr_op_e;
endpackage

// File: rtl/fpr_tag_ctrl.sv
module fpr_tag_ctrl
    import fpr_stack_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [2:0]       op_i,
    input  logic [PTR_W-1:0] idx_a_i,
    input  logic [PTR_W-1:0] idx_b_i,
    output logic [PTR_W-1:0] top_o,
    output logic [DEPTH-1:0] tag_o,
    output logic [PTR_W-1:0] slot_a_o,
    output logic [PTR_W-1:0] slot_b_o,
    output logic             we0_o,
    output logic [PTR_W-1:0] slot0_o,
    output logic             xchg_o,
    output logic             we1_o,
    output logic [PTR_W-1:0] slot1_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam logic [PTR_W-1:0] ONE = 1;

    fpr_op_e          op;
    logic [PTR_W-1:0] top_q, top_d;
    logic [DEPTH-1:0] tag_q, tag_d;
    logic             ovf_q, ovf_d, unf_q, unf_d;
    logic [PTR_W-1:0] slot_a, slot_b, slot_push, top_next;

    assign op        = fpr_op_e'(op_i);
    assign slot_a    = top_q + idx_a_i;
    assign slot_b    = top_q + idx_b_i;
    assign slot_push = top_q - ONE;
    assign top_next  = top_q + ONE;

    // next-state decode
    always_comb begin
        top_d   = top_q;
        tag_d   = tag_q;
        ovf_d   = 1'b0;
        unf_d   = 1'b0;
        we0_o   = 1'b0;
        slot0_o = slot_a;
        we1_o   = 1'b0;
        slot1_o = slot_b;
        xchg_o  = 1'b0;
        if (clear_i) begin
            tag_d = '0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    if (tag_q[slot_push]) begin
                        ovf_d = 1'b1;
                    end else begin
                        we0_o            = 1'b1;
                        slot0_o          = slot_push;
                        tag_d[slot_push] = 1'b1;
                        top_d            = slot_push;
                    end
                end
                OP_POP: begin
                    if (!tag_q[top_q]) begin
                        unf_d = 1'b1;
                    end else begin
                        tag_d[top_q] = 1'b0;
                        top_d        = top_next;
                    end
                end
                OP_XCHG: begin
                    if (!tag_q[slot_a] || !tag_q[slot_b]) begin
                        unf_d = 1'b1;
                    end else begin
                        we0_o  = 1'b1;
                        we1_o  = 1'b1;
                        xchg_o = 1'b1;
                    end
                end
                OP_WB: begin
                    if (!tag_q[slot_a]) unf_d = 1'b1;
                    else                we0_o = 1'b1;
                end
                OP_WBPOP: begin
                    if (!tag_q[slot_a] || !tag_q[top_q]) begin
                        unf_d = 1'b1;
                    end else begin
                        we0_o        = 1'b1;
                        tag_d[top_q] = 1'b0;
                        top_d        = top_next;
                    end
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
            tag_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            top_q <= top_d;
            tag_q <= tag_d;
            ovf_q <= ovf_d;
            unf_q <= unf_d;
        end
    end

    // outputs
    always_comb begin
        top_o    = top_q;
        tag_o    = tag_q;
        slot_a_o = slot_a;
        slot_b_o = slot_b;
        ovf_o    = ovf_q;
        unf_o    = unf_q;
    end

    a_r4_overflow_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> ($stable(top_q) && $stable(tag_q)));
    a_r5_underflow_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |-> ($stable(top_q) && $stable(tag_q)));
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (tag_q == '0));
    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_q && unf_q));
    a_r3_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && !clear_i && tag_q[top_q]) |=> (top_q == $past(top_q) + ONE));
    a_r2_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH && !clear_i && !tag_q[slot_push]) |=> tag_q[top_q]);
endmodule

// File: rtl/fpr_regfile.sv
module fpr_regfile #(
    parameter int DEPTH = 8,
    parameter int W     = 80,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we0_i,
    input  logic [PTR_W-1:0]          slot0_i,
    input  logic [W-1:0]              data0_i,
    input  logic                      we1_i,
    input  logic [PTR_W-1:0]          slot1_i,
    input  logic [W-1:0]              data1_i,
    output logic [DEPTH-1:0][W-1:0]   slots_o
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [PTR_W-1:0] SLOT = PTR_W'(g);
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        q <= '0;
            else if (we1_i && slot1_i == SLOT) q <= data1_i;
            else if (we0_i && slot0_i == SLOT) q <= data0_i;
        end
        assign slots_o[g] = q;
    end
endmodule

// File: rtl/fpr_opnd_sel.sv
module fpr_opnd_sel #(
    parameter int DEPTH = 8,
    parameter int W     = 80,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][W-1:0] slots_i,
    input  logic [DEPTH-1:0]        tag_i,
    input  logic [PTR_W-1:0]        top_i,
    input  logic [PTR_W-1:0]        slot_a_i,
    input  logic                    rev_i,
    output logic [W-1:0]            opnd_a_o,
    output logic [W-1:0]            opnd_b_o,
    output logic                    rd_fault_o
);
    logic [W-1:0] head, sel;

    always_comb begin
        head       = slots_i[top_i];
        sel        = slots_i[slot_a_i];
        rd_fault_o = !tag_i[top_i] || !tag_i[slot_a_i];
        if (rev_i) begin
            opnd_a_o = sel;
            opnd_b_o = head;
        end else begin
            opnd_a_o = head;
            opnd_b_o = sel;
        end
    end
endmodule

// File: rtl/fpr_stack.sv
module fpr_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 80,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [2:0]       op_i,
    input  logic [PTR_W-1:0] idx_a_i,
    input  logic [PTR_W-1:0] idx_b_i,
    input  logic             rev_i,
    input  logic [W-1:0]     data_i,
    output logic [W-1:0]     opnd_a_o,
    output logic [W-1:0]     opnd_b_o,
    output logic             rd_fault_o,
    output logic [PTR_W-1:0] top_o,
    output logic [DEPTH-1:0] tag_o,
    output logic             ovf_o,
    output logic             unf_o
);
    logic [PTR_W-1:0]        slot_a, slot_b, slot0, slot1;
    logic                    we0, we1, xchg;
    logic [DEPTH-1:0][W-1:0] slots;
    logic [W-1:0]            data0, data1;

    fpr_tag_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .op_i(op_i),
        .idx_a_i(idx_a_i), .idx_b_i(idx_b_i), .top_o(top_o), .tag_o(tag_o),
        .slot_a_o(slot_a), .slot_b_o(slot_b), .we0_o(we0), .slot0_o(slot0),
        .xchg_o(xchg), .we1_o(we1), .slot1_o(slot1), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // exchange feeds each slot from the other; otherwise port 0 takes data_i
    assign data0 = xchg ? slots[slot_b] : data_i;
    assign data1 = slots[slot_a];

    fpr_regfile #(.DEPTH(DEPTH), .W(W), .PTR_W(PTR_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we0_i(we0), .slot0_i(slot0), .data0_i(data0),
        .we1_i(we1), .slot1_i(slot1), .data1_i(data1), .slots_o(slots)
    );

    fpr_opnd_sel #(.DEPTH(DEPTH), .W(W), .PTR_W(PTR_W)) u_sel (
        .slots_i(slots), .tag_i(tag_o), .top_i(top_o), .slot_a_i(slot_a),
        .rev_i(rev_i), .opnd_a_o(opnd_a_o), .opnd_b_o(opnd_b_o),
        .rd_fault_o(rd_fault_o)
    );
endmodule

// File: tb/fpr_stack_tb.sv
`timescale 1ns/100ps
module fpr_stack_tb;
    localparam int W = 80;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clear_i = 1'b0;
    logic [2:0]   op_i = '0;
    logic [2:0]   idx_a_i = '0, idx_b_i = '0;
    logic         rev_i = 1'b0;
    logic [W-1:0] data_i = '0;
    logic [W-1:0] opnd_a_o, opnd_b_o;
    logic         rd_fault_o, ovf_o, unf_o;
    logic [2:0]   top_o;
    logic [7:0]   tag_o;

    int n_run = 0, n_fail = 0;

    // behavioural reference
    logic [W-1:0] m_mem [8];
    bit           m_v [8];
    int           m_top;
    bit           m_ovf, m_unf;

    always #2.5 clk = ~clk;

    fpr_stack u_dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .op_i(op_i),
        .idx_a_i(idx_a_i), .idx_b_i(idx_b_i), .rev_i(rev_i), .data_i(data_i),
        .opnd_a_o(opnd_a_o), .opnd_b_o(opnd_b_o), .rd_fault_o(rd_fault_o),
        .top_o(top_o), .tag_o(tag_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_tags();
        logic [7:0] t;
        for (int k = 0; k < 8; k++) t[k] = m_v[k];
        return t;
    endfunction

    task automatic model(input int op, input int ia, input int ib,
                         input logic [W-1:0] d, input bit clr);
        int a, b, p;
        logic [W-1:0] tmp;
        a = (m_top + ia) % 8;
        b = (m_top + ib) % 8;
        m_ovf = 0;
        m_unf = 0;
        if (clr) begin
            for (int k = 0; k < 8; k++) m_v[k] = 0;
        end else begin
            case (op)
                1: begin
                    p = (m_top + 7) % 8;
                    if (m_v[p]) m_ovf = 1;
                    else begin m_mem[p] = d; m_v[p] = 1; m_top = p; end
                end
                2: if (!m_v[m_top]) m_unf = 1;
                   else begin m_v[m_top] = 0; m_top = (m_top + 1) % 8; end
                3: if (!m_v[a] || !m_v[b]) m_unf = 1;
                   else begin tmp = m_mem[a]; m_mem[a] = m_mem[b]; m_mem[b] = tmp; end
                4: if (!m_v[a]) m_unf = 1;
                   else m_mem[a] = d;
                5: if (!m_v[a] || !m_v[m_top]) m_unf = 1;
                   else begin m_mem[a] = d; m_v[m_top] = 0; m_top = (m_top + 1) % 8; end
                default: ;
            endcase
        end
    endtask

    task automatic check_state(input string req);
        chk(top_o == 3'(m_top), req, "top", W'(top_o), W'(m_top));
        chk(tag_o == exp_tags(), req, "tags", W'(tag_o), W'(exp_tags()));
        chk(ovf_o == m_ovf, req, "ovf", W'(ovf_o), W'(m_ovf));
        chk(unf_o == m_unf, req, "unf", W'(unf_o), W'(m_unf));
    endtask

    // inputs driven at negedge; comb outputs checked before the edge,
    // registered outputs at the following negedge
    task automatic step(input int op, input int ia, input int ib,
                        input logic [W-1:0] d, input bit rev, input bit clr,
                        input string req);
        int a;
        logic [W-1:0] hd, sl;
        op_i = 3'(op); idx_a_i = 3'(ia); idx_b_i = 3'(ib);
        data_i = d; rev_i = rev; clear_i = clr;
        #1;
        a  = (m_top + ia) % 8;
        hd = m_mem[m_top];
        sl = m_mem[a];
        chk(opnd_a_o == (rev ? sl : hd), req, "opnd_a", opnd_a_o, rev ? sl : hd);
        chk(opnd_b_o == (rev ? hd : sl), req, "opnd_b", opnd_b_o, rev ? hd : sl);
        chk(rd_fault_o == (!m_v[m_top] || !m_v[a]), req, "rd_fault",
            W'(rd_fault_o), W'(!m_v[m_top] || !m_v[a]));
        @(posedge clk);
        model(op, ia, ib, d, clr);
        @(negedge clk);
        check_state(req);
    endtask

    initial begin
        #(5.0 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) begin m_mem[k] = '0; m_v[k] = 0; end
        m_top = 0; m_ovf = 0; m_unf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1");
        // R2 pushes, pointer wraps from 0 to 7
        step(1, 0, 0, 80'hA1, 0, 0, "R2");
        step(1, 0, 0, 80'hB2, 0, 0, "R2");
        step(1, 0, 0, 80'hC3, 0, 0, "R2");
        // R6 and R10 operand selection
        step(0, 2, 0, 80'h0, 0, 0, "R6");
        step(0, 2, 0, 80'h0, 1, 0, "R10");
        step(0, 5, 0, 80'h0, 0, 0, "R6_unpushed");
        // R7 exchange
        step(3, 0, 2, 80'h0, 0, 0, "R7");
        step(0, 2, 0, 80'h0, 0, 0, "R7");
        // R8 write-back
        step(4, 1, 0, 80'hD4, 0, 0, "R8");
        step(0, 1, 0, 80'h0, 0, 0, "R8");
        // R9 write-back-pop, i=1: result becomes top
        step(5, 1, 0, 80'hE5, 0, 0, "R9");
        step(0, 0, 0, 80'h0, 0, 0, "R9");
        // R9 with i=0: result leaves with the popped top
        step(5, 0, 0, 80'hF6, 0, 0, "R9");
        // R3 pop, then R5 underflow on empty
        step(2, 0, 0, 80'h0, 0, 0, "R3");
        step(2, 0, 0, 80'h0, 0, 0, "R5");
        step(0, 0, 0, 80'h0, 0, 0, "R12");
        step(3, 0, 1, 80'h0, 0, 0, "R5");
        step(4, 3, 0, 80'h77, 0, 0, "R5");
        step(5, 0, 0, 80'h77, 0, 0, "R5");
        // R4 fill eight, ninth overflows
        for (int k = 0; k < 8; k++) step(1, 0, 0, W'(k + 16), 0, 0, "R2");
        step(1, 0, 0, 80'h99, 0, 0, "R4");
        step(0, 7, 0, 80'h0, 0, 0, "R12");
        step(3, 3, 7, 80'h0, 0, 0, "R7");
        // R11 clear beats a live operation
        step(2, 0, 0, 80'h0, 0, 1, "R11");
        step(1, 0, 0, 80'h55, 0, 1, "R11");
        step(0, 0, 0, 80'h0, 0, 0, "R11");
        // mixed run
        for (int k = 0; k < 400; k++)
            step($urandom_range(0, 5), $urandom_range(0, 7), $urandom_range(0, 7),
                 {$urandom, $urandom, 16'($urandom)}, 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 31) == 0), "R12_mix");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule